// File: doc/BRIEF.md
# Multi-key reset detector

This block turns a chosen group of active-low key inputs into an internal reset request. A static group selector names the group. A value of zero turns the feature off. A value n from 1 upward selects keys 0 through n, so the supported groups are keys 0-1, keys 0-2 and keys 0-3. The keys are brought into the slow-clock domain through a synchroniser chain. They are then checked for the case where every selected key is LOW at once.

In normal operation the group must stay LOW for a long qualification interval, counted in slow-clock cycles. This rejects accidental presses. When the interval completes, the block issues a reset pulse of fixed length, so the system restarts even if the keys are still held. The block then waits for the group to be released before it can fire again.

When the sleep flag or the oscillator-settling flag is active, qualification is skipped. The reset asserts as soon as the synchronised group is seen and stays asserted until the group is released. Both flags are expected to be synchronous to the slow clock.

Top module: `multikey_reset`

## Requirements
- R1: The selector `group_sel_i` codes the group: 0 = feature off, 1 = keys 0 and 1, 2 = keys 0 to 2, 3 = keys 0 to 3. Key i is bit i of `keys_ni`, and LOW means pressed.
- R2: A request needs every selected key LOW at the same time. Keys outside the group have no effect, and a partial group never asserts `key_rst_o`.
- R3: Each key passes through a two-stage synchroniser before it is evaluated. With a flag active, a group driven LOW does not raise `key_rst_o` after the second rising edge, but does after the third.
- R4: With both flags inactive, `key_rst_o` rises after the (QUAL_CYCLES+2)-th rising edge following the group going LOW and staying LOW. It is still low after the (QUAL_CYCLES+1)-th edge.
- R5: If any selected key goes HIGH before qualification completes, the count clears. A full new interval is then needed from the next time the group goes LOW.
- R6: A timed reset pulse lasts exactly PULSE_CYCLES cycles and then releases, even while the group stays LOW.
- R7: After a timed pulse, no further reset happens until the group has been released at least once, however long the keys stay LOW.
- R8: When `sleep_i` or `settle_i` is HIGH, the reset asserts without the qualification wait.
- R9: A reset raised through the bypass path stays HIGH while the group is held. It drops after the third rising edge following the release.
- R10: With selector 0, `key_rst_o` never asserts, whatever the keys and flags do.
- R11: While `rst_ni` is LOW, and right after it is released, `key_rst_o` is LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow_i | input | 1 | Slow clock that drives synchronisation and timing |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| keys_ni | input | NUM_KEYS | Raw key levels, LOW = pressed |
| group_sel_i | input | SEL_W | Static group selector (0 = off) |
| sleep_i | input | 1 | Sleep flag, bypasses qualification |
| settle_i | input | 1 | Oscillator-settling flag, bypasses qualification |
| key_rst_o | output | 1 | Registered reset request |

## Verification
A key change reaches the detector after two edges. The state, and the registered output with it, changes on the third edge. So a bypass reset is due after edge 3, a timed reset after edge QUAL_CYCLES+2, and its release after PULSE_CYCLES further edges. The directed checks drive inputs on a falling edge, count the exact number of rising edges, and sample on the next falling edge. A cycle-level bench model also compares the output on every falling edge. It covers both the directed sequences and the seeded random segments of selector, key, sleep and settle values, with reduced interval lengths so that many qualifications fit in the run.

// File: rtl/mkr_pkg.sv
package mkr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_QUAL  = 3'd1,
      ST_PULSE = 3'd2,
      ST_HOLD  = 3'd3,
      ST_LOCK  = 3'd4
   } mkr_state_e;

   function automatic int unsigned mkr_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mkr_key_sync.sv
module mkr_key_sync #(
   parameter int   WIDTH     = 4,
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1)  $error("mkr_key_sync: WIDTH must be at least 1");
   if (STAGES < 2) $error("mkr_key_sync: STAGES must be at least 2");

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stage_q <= {STAGES{{WIDTH{RESET_VAL}}}};
      end else begin
         stage_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) begin
            stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];

   // R3: the last stage trails the one before it by exactly one edge
   p_sync_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_o == $past(stage_q[STAGES-2]))
      else $error("p_sync_shift_r3");

endmodule

// File: rtl/mkr_combo_match.sv
module mkr_combo_match #(
   parameter int NUM_KEYS = 4,
   parameter int SEL_W    = 2
) (
   input  logic [NUM_KEYS-1:0] keys_ni,
   input  logic [SEL_W-1:0]    sel_i,
   output logic                combo_o
);

   if (NUM_KEYS < 2) $error("mkr_combo_match: at least two keys are needed");
   if ((1 << SEL_W) < NUM_KEYS) $error("mkr_combo_match: SEL_W too narrow");

   logic [NUM_KEYS-1:0] mask;

   // group n covers keys 0..n; selector 0 switches the feature off
   for (genvar i = 0; i < NUM_KEYS; i++) begin : g_mask
      assign mask[i] = (sel_i != '0) && (i <= int'(sel_i));
   end

   assign combo_o = (|mask) && ((keys_ni & mask) == '0);

endmodule

// File: rtl/mkr_qual_fsm.sv
module mkr_qual_fsm
   import mkr_pkg::*;
#(
   parameter int unsigned QUAL_CYCLES  = 65536,
   parameter int unsigned PULSE_CYCLES = 64
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic combo_i,
   input  logic bypass_i,
   output logic rst_req_o
);

   localparam int unsigned MAX_CNT = mkr_max(QUAL_CYCLES, PULSE_CYCLES);
   localparam int          CNT_W   = $clog2(MAX_CNT + 1);
   localparam logic [CNT_W-1:0] QUAL_LAST  = CNT_W'(QUAL_CYCLES - 1);
   localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYCLES - 1);

   if (QUAL_CYCLES < 2)  $error("mkr_qual_fsm: QUAL_CYCLES must be at least 2");
   if (PULSE_CYCLES < 1) $error("mkr_qual_fsm: PULSE_CYCLES must be at least 1");

   mkr_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             rst_q;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         ST_IDLE: begin
            if (combo_i) begin
               if (bypass_i) begin
                  state_d = ST_HOLD;
               end else begin
                  state_d = ST_QUAL;
                  cnt_d   = CNT_W'(1);
               end
            end
         end
         ST_QUAL: begin
            if (!combo_i) begin
               state_d = ST_IDLE;
               cnt_d   = '0;
            end else if (bypass_i) begin
               state_d = ST_HOLD;
               cnt_d   = '0;
            end else if (cnt_q == QUAL_LAST) begin
               state_d = ST_PULSE;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + CNT_W'(1);
            end
         end
         ST_PULSE: begin
            if (cnt_q == PULSE_LAST) begin
               cnt_d   = '0;
               state_d = combo_i ? ST_LOCK : ST_IDLE;
            end else begin
               cnt_d = cnt_q + CNT_W'(1);
            end
         end
         ST_HOLD: begin
            if (!combo_i) state_d = ST_IDLE;
         end
         ST_LOCK: begin
            if (!combo_i) state_d = ST_IDLE;
         end
         default: begin
            state_d = ST_IDLE;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         rst_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         rst_q   <= (state_d == ST_PULSE) || (state_d == ST_HOLD);
      end
   end

   assign rst_req_o = rst_q;

   // R2: no request leaves idle without the full group
   p_idle_needs_group_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_IDLE && !combo_i) |=> (state_q == ST_IDLE && !rst_req_o))
      else $error("p_idle_needs_group_r2");

   // R4: qualification count stays inside its window
   p_qual_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_QUAL) |-> (cnt_q != '0 && cnt_q <= QUAL_LAST && !rst_req_o))
      else $error("p_qual_bound_r4");

   // R5: a released key during qualification clears the count
   p_abort_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_QUAL && !combo_i) |=> (state_q == ST_IDLE && cnt_q == '0))
      else $error("p_abort_clears_r5");

   // R6: pulse length is bounded and the pulse always ends
   p_pulse_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_PULSE) |-> (cnt_q <= PULSE_LAST && rst_req_o))
      else $error("p_pulse_bound_r6");

   p_pulse_ends_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_PULSE && cnt_q == PULSE_LAST) |=> !rst_req_o)
      else $error("p_pulse_ends_r6");

   // R7: held keys after a pulse cannot retrigger
   p_no_retrigger_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_LOCK && combo_i) |=> (state_q == ST_LOCK && !rst_req_o))
      else $error("p_no_retrigger_r7");

   // R8: bypass asserts reset on the next edge
   p_bypass_now_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_IDLE && combo_i && bypass_i) |=> rst_req_o)
      else $error("p_bypass_now_r8");

   // R9: bypass reset follows the group
   p_hold_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_HOLD && combo_i) |=> rst_req_o)
      else $error("p_hold_keeps_r9");

   p_hold_drops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_HOLD && !combo_i) |=> !rst_req_o)
      else $error("p_hold_drops_r9");

endmodule

// File: rtl/multikey_reset.sv
module multikey_reset #(
   parameter int          NUM_KEYS     = 4,
   parameter int          SYNC_STAGES  = 2,
   parameter int unsigned QUAL_CYCLES  = 65536,
   parameter int unsigned PULSE_CYCLES = 64,
   localparam int         SEL_W        = $clog2(NUM_KEYS)
) (
   input  logic                clk_slow_i,
   input  logic                rst_ni,
   input  logic [NUM_KEYS-1:0] keys_ni,
   input  logic [SEL_W-1:0]    group_sel_i,
   input  logic                sleep_i,
   input  logic                settle_i,
   output logic                key_rst_o
);

   logic [NUM_KEYS-1:0] keys_sync;
   logic                combo;
   logic                bypass;

   mkr_key_sync #(
      .WIDTH     (NUM_KEYS),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk_i  (clk_slow_i),
      .rst_ni (rst_ni),
      .d_i    (keys_ni),
      .q_o    (keys_sync)
   );

   mkr_combo_match #(
      .NUM_KEYS (NUM_KEYS),
      .SEL_W    (SEL_W)
   ) u_match (
      .keys_ni (keys_sync),
      .sel_i   (group_sel_i),
      .combo_o (combo)
   );

   assign bypass = sleep_i | settle_i;

   mkr_qual_fsm #(
      .QUAL_CYCLES  (QUAL_CYCLES),
      .PULSE_CYCLES (PULSE_CYCLES)
   ) u_fsm (
      .clk_i     (clk_slow_i),
      .rst_ni    (rst_ni),
      .combo_i   (combo),
      .bypass_i  (bypass),
      .rst_req_o (key_rst_o)
   );

   // R10: with the feature off, a quiet output stays quiet
   p_disabled_quiet_r10: assert property (@(posedge clk_slow_i) disable iff (!rst_ni)
      (group_sel_i == '0 && !key_rst_o) |=> !key_rst_o)
      else $error("p_disabled_quiet_r10");

endmodule

// File: tb/multikey_reset_tb_top.sv
module multikey_reset_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int QUAL       = 300;
   localparam int PULSE      = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] keys = 4'hF;
   logic [1:0] sel = 2'd0;
   logic       sleep = 1'b0;
   logic       settle = 1'b0;
   logic       key_rst;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   multikey_reset #(
      .NUM_KEYS     (4),
      .SYNC_STAGES  (2),
      .QUAL_CYCLES  (QUAL),
      .PULSE_CYCLES (PULSE)
   ) dut_i (
      .clk_slow_i  (clk),
      .rst_ni      (rst_n),
      .keys_ni     (keys),
      .group_sel_i (sel),
      .sleep_i     (sleep),
      .settle_i    (settle),
      .key_rst_o   (key_rst)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
      end
   endtask

   // R1: group n means keys 0..n, selector 0 is off
   function automatic bit group_low(input logic [3:0] k, input logic [1:0] s);
      if (s == 2'd0) return 1'b0;
      for (int i = 0; i <= int'(s); i++) if (k[i]) return 1'b0;
      return 1'b1;
   endfunction

   // cycle model from the requirements: phase 0 idle, 1 counting, 2 pulse, 3 held, 4 locked
   int         m_ph = 0;
   int         m_cnt = 0;
   logic [3:0] m_d1 = 4'hF, m_d2 = 4'hF;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_d1 = 4'hF; m_d2 = 4'hF;
      end else begin
         bit g, b;
         g = group_low(m_d2, sel);
         b = sleep | settle;
         case (m_ph)
            0: if (g) begin
                  if (b) m_ph = 3; else begin m_ph = 1; m_cnt = 1; end
               end
            1: if (!g) begin m_ph = 0; m_cnt = 0; end
               else if (b) begin m_ph = 3; m_cnt = 0; end
               else if (m_cnt == QUAL-1) begin m_ph = 2; m_cnt = 0; end
               else m_cnt++;
            2: if (m_cnt == PULSE-1) begin m_cnt = 0; m_ph = g ? 4 : 0; end
               else m_cnt++;
            default: if (!g) m_ph = 0;
         endcase
         m_d2 = m_d1;
         m_d1 = keys;
      end
   end

   function automatic string phase_tag(input int ph);
      case (ph)
         1: return "R4";
         2: return "R6";
         3: return "R9";
         4: return "R7";
         default: return "R2";
      endcase
   endfunction

   always @(negedge clk) begin
      if (rst_n) chk(phase_tag(m_ph), "cycle model", key_rst, (m_ph == 2 || m_ph == 3));
   end

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic release_all();
      keys = 4'hF; sleep = 1'b0; settle = 1'b0;
      edges(PULSE + 8);
   endtask

   initial begin
      repeat (QUAL * 500) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got hung expected finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      // R11 reset state
      edges(1);
      chk("R11", "during reset", key_rst, 1'b0);
      edges(3);
      rst_n = 1'b1;
      edges(2);
      chk("R11", "after reset", key_rst, 1'b0);

      // R10 feature off, keys low with and without bypass
      sel = 2'd0; keys = 4'h0;
      edges(QUAL + PULSE + 10);
      chk("R10", "off, timed", key_rst, 1'b0);
      sleep = 1'b1;
      edges(10);
      chk("R10", "off, sleep", key_rst, 1'b0);
      release_all();

      // R2 partial group: key 3 high with group of four
      sel = 2'd3; keys = 4'b1000;
      edges(QUAL + 10);
      chk("R2", "key 3 high", key_rst, 1'b0);
      release_all();

      // R1/R4 group of two, unselected keys high; exact edge of assertion
      sel = 2'd1; keys = 4'b1100;
      edges(QUAL + 1);
      chk("R4", "one edge early", key_rst, 1'b0);
      edges(1);
      chk("R1", "group 0-1 fires", key_rst, 1'b1);
      // R6 pulse length while keys held
      edges(PULSE - 1);
      chk("R6", "last pulse cycle", key_rst, 1'b1);
      edges(1);
      chk("R6", "pulse released", key_rst, 1'b0);
      // R7 held keys do not retrigger
      edges(2 * QUAL);
      chk("R7", "still held", key_rst, 1'b0);
      release_all();

      // R5 a one-cycle release restarts the count (group 0-2)
      sel = 2'd2; keys = 4'b1000;
      edges(100);
      keys = 4'b1010;
      edges(1);
      keys = 4'b1000;
      edges(QUAL + 1);
      chk("R5", "restarted count", key_rst, 1'b0);
      edges(1);
      chk("R5", "fires after full interval", key_rst, 1'b1);
      release_all();

      // R3/R8 sleep bypass
      sel = 2'd3; sleep = 1'b1; keys = 4'h0;
      edges(2);
      chk("R3", "sync latency", key_rst, 1'b0);
      edges(1);
      chk("R8", "sleep immediate", key_rst, 1'b1);
      // R9 held well beyond the timed pulse
      edges(QUAL + PULSE);
      chk("R9", "held in sleep", key_rst, 1'b1);
      keys = 4'h1;
      edges(2);
      chk("R9", "release latency", key_rst, 1'b1);
      edges(1);
      chk("R9", "released", key_rst, 1'b0);
      release_all();

      // R8 settling bypass
      sel = 2'd1; settle = 1'b1; keys = 4'b0100;
      edges(3);
      chk("R8", "settle immediate", key_rst, 1'b1);
      release_all();

      // random segments checked by the cycle model
      for (int seg = 0; seg < 60; seg++) begin
         int dur;
         sel    = 2'($urandom_range(0, 3));
         keys   = 4'($urandom);
         if ($urandom_range(0, 1) == 1) keys = keys & ~4'((2 << sel) - 1);
         sleep  = ($urandom_range(0, 5) == 0);
         settle = ($urandom_range(0, 7) == 0);
         dur    = $urandom_range(1, QUAL + QUAL / 2);
         edges(dur);
      end
      release_all();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule